// File: doc/BRIEF.md
# Fabric Configuration Loader

This block lets a host processor load a configuration image into a programmable fabric through a small word-addressed register bus. The host takes over the fabric's configuration pins and pulses the configuration-reset line. It then pushes image words through a gated data path, which serialises each word into 8-, 16- or 32-bit beats on the configuration bus. Each beat carries one data clock pulse.

Once the fabric raises its done pin, the host requests a burst of initialization clocks from a counter and polls a sticky completion flag. A phase tracker runs from the synchronised nSTATUS and CONF_DONE pins and the burst completion. It reports reset, configuration, initialization, user and error phases. A falling nSTATUS latches an interrupt flag, and the host clears it through an acknowledge register.

Register offsets (word index on `bus_addr_i`): 0 control, 1 status, 2 pin monitor, 3 interrupt acknowledge, 4 clock count, 5 clock status, 6 data. Reads are combinational. A write is one cycle with `bus_req_i` and `bus_we_i` high.

Top module: `fabric_cfg_ctrl`

## Requirements
- R1: After reset, the control register reads 0x10, the status phase field (offset 1, bits 2:0) reads 0, the clock status (offset 5, bit 0) reads 0, the interrupt flag is 0 and `cfg_nce_o` is 1. Control layout: bits 1:0 ratio, bits 3:2 width, bit 4 chip-enable (active low, drives `cfg_nce_o`), bit 5 takeover, bit 6 reset pull, bit 7 data enable.
- R2: With the takeover bit at 0, `cfg_nconfig_o`, `cfg_dclk_o` and `cfg_data_o` follow `ext_nconfig_i`, `ext_dclk_i` and `ext_data_i`. With it at 1, the controller drives them, and `cfg_nconfig_o` is the inverse of the reset pull bit.
- R3: The phase field reads 0 while the configuration-reset line is low. It reads 1 after the line is high and nSTATUS is high.
- R4: A data write (offset 6) made while the data enable bit is 0 produces no pulse on `cfg_dclk_o`.
- R5: Width 0 sends a word as 4 beats of 8 bits, width 1 as 2 beats of 16 bits, and width 2 or 3 as one 32-bit beat. Beats go least significant first on the low lanes, with the unused upper lanes at zero. Each beat is one high cycle of `cfg_dclk_o`.
- R6: Successive beats of one word start (2 << ratio) clock cycles apart.
- R7: The pin monitor (offset 2) shows nSTATUS in bit 0 and CONF_DONE in bit 1. CONF_DONE rising during the configuration phase moves the phase to 2.
- R8: Writing N > 0 to the count register (offset 4) while idle emits exactly N pulses on `cfg_dclk_o`. Each pulse is one high cycle followed by one low cycle. A count written while a burst runs is ignored.
- R9: The completion flag (offset 5, bit 0) is set after the last pulse. It stays set until a write with bit 0 set. A burst that completes in phase 2 moves the phase to 3.
- R10: nSTATUS falling during the configuration phase moves the phase to 4. The phase stays 4 until the configuration-reset line is pulled low.
- R11: A falling nSTATUS sets pin monitor bit 2 and `irq_o`. Writing bit 0 as 1 to offset 3 clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Register access request |
| bus_we_i | input | 1 | Write when high |
| bus_addr_i | input | AW | Word offset |
| bus_wdata_i | input | DW | Write data |
| bus_rdata_o | output | DW | Read data, combinational |
| ext_nconfig_i | input | 1 | External configuration-reset line |
| ext_dclk_i | input | 1 | External data clock |
| ext_data_i | input | DW | External configuration data |
| nstatus_i | input | 1 | Fabric status pin |
| conf_done_i | input | 1 | Fabric done pin |
| cfg_nconfig_o | output | 1 | Configuration-reset line to fabric, active low |
| cfg_dclk_o | output | 1 | Data clock to fabric |
| cfg_data_o | output | DW | Configuration data to fabric |
| cfg_nce_o | output | 1 | Chip enable to fabric, active low |
| irq_o | output | 1 | Latched nSTATUS interrupt |

## Verification
The hardest situation to reach is the error phase. It requires nSTATUS to fall while the tracker is already in configuration, after a full pull-and-release sequence has brought nSTATUS high. The fabric model in the bench has a kill control that forces nSTATUS low after the host has polled the configuration phase and cleared the interrupt raised by the earlier pull. A second hard case is a count written during a running burst. The bench issues it one bus cycle after the first count and counts every data-clock pulse.

// File: rtl/fcc_pkg.sv
package fcc_pkg;
  typedef enum logic [2:0] {
    PH_RESET  = 3'd0,
    PH_CONFIG = 3'd1,
    PH_INIT   = 3'd2,
    PH_USER   = 3'd3,
    PH_ERROR  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    WID_8  = 2'd0,
    WID_16 = 2'd1,
    WID_32 = 2'd2
  } width_e;

  typedef struct packed {
    logic       dpath_en;
    logic       pull;
    logic       own;
    logic       ce_n;
    logic [1:0] width;
    logic [1:0] ratio;
  } ctrl_t;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_STAT  = 1;
  localparam int OFS_PINS  = 2;
  localparam int OFS_EOI   = 3;
  localparam int OFS_DCNT  = 4;
  localparam int OFS_DSTAT = 5;
  localparam int OFS_DATA  = 6;

  localparam ctrl_t CTRL_RST = '{dpath_en: 1'b0, pull: 1'b0, own: 1'b0,
                                 ce_n: 1'b1, width: 2'd0, ratio: 2'd0};
endpackage

// File: rtl/fcc_sync.sv
module fcc_sync #(
  parameter int STAGES = 2,
  parameter int W      = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= {st_q[STAGES-2:0], d_i};
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/fcc_dclk_burst.sv
module fcc_dclk_burst #(
  parameter int CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] count_i,
  input  logic          clr_i,
  output logic          dclk_o,
  output logic          busy_o,
  output logic [CW-1:0] remain_o,
  output logic          done_o,
  output logic          fin_o
);
  logic last;
  assign last = busy_o && !dclk_o && (remain_o == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dclk_o   <= 1'b0;
      busy_o   <= 1'b0;
      remain_o <= '0;
      fin_o    <= 1'b0;
    end else begin
      fin_o <= 1'b0;
      if (!busy_o) begin
        if (load_i && count_i != '0) begin
          remain_o <= count_i;
          busy_o   <= 1'b1;
          dclk_o   <= 1'b1;
        end
      end else if (dclk_o) begin
        dclk_o <= 1'b0;
      end else begin
        remain_o <= remain_o - CW'(1);
        if (last) begin
          busy_o <= 1'b0;
          fin_o  <= 1'b1;
        end else begin
          dclk_o <= 1'b1;
        end
      end
    end
  end

  // set wins over a simultaneous clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    done_o <= 1'b0;
    else if (last)  done_o <= 1'b1;
    else if (clr_i) done_o <= 1'b0;
  end
endmodule

// File: rtl/fcc_packer.sv
module fcc_packer
  import fcc_pkg::*;
#(
  parameter int DW = 32,
  parameter int RW = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] word_i,
  input  logic [1:0]    width_i,
  input  logic [RW-1:0] ratio_i,
  output logic [DW-1:0] dat_o,
  output logic          stb_o,
  output logic          busy_o
);
  localparam int NB = DW / 8;
  localparam int BW = $clog2(NB) + 1;
  localparam int GW = (1 << RW) + 1;

  logic [DW-1:0] sh_q, lane_mask;
  logic [BW-1:0] beats_q, beats_init;
  logic [GW-1:0] gap_q, gap_init;
  logic [1:0]    width_q;
  logic [RW-1:0] ratio_q;
  int            lane_bits;

  always_comb begin
    case (width_e'(width_q))
      WID_8:   lane_bits = 8;
      WID_16:  lane_bits = 16;
      default: lane_bits = DW;
    endcase
    case (width_e'(width_i))
      WID_8:   beats_init = BW'(NB);
      WID_16:  beats_init = BW'(NB / 2);
      default: beats_init = BW'(1);
    endcase
    lane_mask = {DW{1'b1}} >> (DW - lane_bits);
    gap_init  = GW'((32'd2 << ratio_q) - 32'd1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      dat_o   <= '0;
      stb_o   <= 1'b0;
      busy_o  <= 1'b0;
      beats_q <= '0;
      gap_q   <= '0;
      width_q <= '0;
      ratio_q <= '0;
    end else begin
      stb_o <= 1'b0;
      if (!busy_o) begin
        if (wr_i) begin
          sh_q    <= word_i;
          beats_q <= beats_init;
          gap_q   <= '0;
          width_q <= width_i;
          ratio_q <= ratio_i;
          busy_o  <= 1'b1;
        end
      end else if (gap_q != '0) begin
        gap_q <= gap_q - GW'(1);
      end else begin
        stb_o   <= 1'b1;
        dat_o   <= sh_q & lane_mask;
        sh_q    <= sh_q >> lane_bits;
        beats_q <= beats_q - BW'(1);
        gap_q   <= gap_init;
        if (beats_q == BW'(1)) busy_o <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fcc_phase.sv
module fcc_phase
  import fcc_pkg::*;
(
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   ncfg_i,
  input  logic   nst_i,
  input  logic   cd_i,
  input  logic   init_fin_i,
  output phase_e phase_o
);
  phase_e nxt;

  always_comb begin
    nxt = phase_o;
    if (!ncfg_i) nxt = PH_RESET;
    else begin
      case (phase_o)
        PH_RESET:  if (nst_i) nxt = PH_CONFIG;
        PH_CONFIG: if (!nst_i) nxt = PH_ERROR;
                   else if (cd_i) nxt = PH_INIT;
        PH_INIT:   if (init_fin_i) nxt = PH_USER;
        default:   nxt = phase_o;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_o <= PH_RESET;
    else         phase_o <= nxt;
  end
endmodule

// File: rtl/fabric_cfg_ctrl.sv
module fabric_cfg_ctrl
  import fcc_pkg::*;
#(
  parameter int DW          = 32,
  parameter int AW          = 3,
  parameter int CW          = 16,
  parameter int RW          = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bus_req_i,
  input  logic          bus_we_i,
  input  logic [AW-1:0] bus_addr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  input  logic          ext_nconfig_i,
  input  logic          ext_dclk_i,
  input  logic [DW-1:0] ext_data_i,
  input  logic          nstatus_i,
  input  logic          conf_done_i,
  output logic          cfg_nconfig_o,
  output logic          cfg_dclk_o,
  output logic [DW-1:0] cfg_data_o,
  output logic          cfg_nce_o,
  output logic          irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t         ctrl;
  phase_e        phase;
  logic          wr, data_wr, dstat_clr, eoi_clr, dcnt_wr;
  logic          ncfg_s, nst_s, cd_s, nst_q, irq;
  logic          burst_dclk, burst_busy, dclk_done, burst_fin;
  logic [CW-1:0] burst_rem;
  logic          pk_stb, pk_busy;
  logic [DW-1:0] pk_dat;
  logic          dpath_en;

  assign wr        = bus_req_i & bus_we_i;
  assign data_wr   = wr && bus_addr_i == AW'(OFS_DATA);
  assign dcnt_wr   = wr && bus_addr_i == AW'(OFS_DCNT);
  assign dstat_clr = wr && bus_addr_i == AW'(OFS_DSTAT) && bus_wdata_i[0];
  assign eoi_clr   = wr && bus_addr_i == AW'(OFS_EOI) && bus_wdata_i[0];
  assign dpath_en  = ctrl.dpath_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl <= CTRL_RST;
    else if (wr && bus_addr_i == AW'(OFS_CTRL)) ctrl <= ctrl_t'(bus_wdata_i[CTRL_W-1:0]);
  end

  // pin takeover
  assign cfg_nconfig_o = ctrl.own ? ~ctrl.pull : ext_nconfig_i;
  assign cfg_dclk_o    = ctrl.own ? (pk_stb | burst_dclk) : ext_dclk_i;
  assign cfg_data_o    = ctrl.own ? pk_dat : ext_data_i;
  assign cfg_nce_o     = ctrl.ce_n;

  fcc_sync #(.STAGES(SYNC_STAGES), .W(3)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({cfg_nconfig_o, nstatus_i, conf_done_i}),
    .q_o   ({ncfg_s, nst_s, cd_s})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      nst_q <= 1'b0;
      irq   <= 1'b0;
    end else begin
      nst_q <= nst_s;
      if (nst_q && !nst_s) irq <= 1'b1;
      else if (eoi_clr)    irq <= 1'b0;
    end
  end
  assign irq_o = irq;

  fcc_packer #(.DW(DW), .RW(RW)) u_packer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .wr_i   (data_wr & dpath_en),
    .word_i (bus_wdata_i),
    .width_i(ctrl.width),
    .ratio_i(ctrl.ratio),
    .dat_o  (pk_dat),
    .stb_o  (pk_stb),
    .busy_o (pk_busy)
  );

  fcc_dclk_burst #(.CW(CW)) u_burst (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (dcnt_wr),
    .count_i (bus_wdata_i[CW-1:0]),
    .clr_i   (dstat_clr),
    .dclk_o  (burst_dclk),
    .busy_o  (burst_busy),
    .remain_o(burst_rem),
    .done_o  (dclk_done),
    .fin_o   (burst_fin)
  );

  fcc_phase u_phase (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ncfg_i    (ncfg_s),
    .nst_i     (nst_s),
    .cd_i      (cd_s),
    .init_fin_i(burst_fin),
    .phase_o   (phase)
  );

  always_comb begin
    bus_rdata_o = '0;
    case (int'(bus_addr_i))
      OFS_CTRL:  bus_rdata_o = DW'(ctrl);
      OFS_STAT:  bus_rdata_o = DW'({pk_busy, burst_busy, phase});
      OFS_PINS:  bus_rdata_o = DW'({irq, cd_s, nst_s});
      OFS_DCNT:  bus_rdata_o = DW'(burst_rem);
      OFS_DSTAT: bus_rdata_o = DW'(dclk_done);
      default:   bus_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/fcc_checker.sv
module fcc_checker
  import fcc_pkg::*;
(
  input logic   clk_i,
  input logic   rst_ni,
  input phase_e phase,
  input logic   burst_dclk,
  input logic   dclk_done,
  input logic   dstat_clr,
  input logic   pk_stb,
  input logic   pk_busy,
  input logic   data_wr,
  input logic   dpath_en,
  input logic   irq,
  input logic   eoi_clr
);
  a_r8_pulse_low_after_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    burst_dclk |=> !burst_dclk);

  a_r9_done_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dclk_done && !dstat_clr) |=> dclk_done);

  a_r9_user_from_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_USER && $past(phase) != PH_USER) |-> $past(phase) == PH_INIT);

  a_r10_error_from_config: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase == PH_ERROR && $past(phase) != PH_ERROR) |-> $past(phase) == PH_CONFIG);

  a_r4_drop_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && !dpath_en && !pk_busy) |=> !pk_busy);

  a_r5_beat_single_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pk_stb |=> !pk_stb);

  a_r11_irq_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq && !eoi_clr) |=> irq);
endmodule

bind fabric_cfg_ctrl fcc_checker u_fcc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .phase     (phase),
  .burst_dclk(burst_dclk),
  .dclk_done (dclk_done),
  .dstat_clr (dstat_clr),
  .pk_stb    (pk_stb),
  .pk_busy   (pk_busy),
  .data_wr   (data_wr),
  .dpath_en  (dpath_en),
  .irq       (irq),
  .eoi_clr   (eoi_clr)
);

// File: tb/fabric_cfg_ctrl_bench.sv
module fabric_cfg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        ext_ncfg = 1'b0, ext_dclk = 1'b0;
  logic [31:0] ext_data = '0;
  logic        fab_nst = 1'b0, fab_cd = 1'b0, fab_kill = 1'b0;
  logic        cfg_ncfg, cfg_dclk, cfg_nce, irq;
  logic [31:0] cfg_data;

  int checks = 0, errors = 0, cyc = 0, n = 0, rel_cnt = 0;
  int beat_base = 0, expect_beats = 0;
  logic [31:0] cap [256];
  int          stamp [256];

  always #5 clk = ~clk;

  fabric_cfg_ctrl u_fabric_cfg_ctrl (
    .clk_i(clk), .rst_ni(rst_n),
    .bus_req_i(req), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .ext_nconfig_i(ext_ncfg), .ext_dclk_i(ext_dclk), .ext_data_i(ext_data),
    .nstatus_i(fab_nst), .conf_done_i(fab_cd),
    .cfg_nconfig_o(cfg_ncfg), .cfg_dclk_o(cfg_dclk), .cfg_data_o(cfg_data),
    .cfg_nce_o(cfg_nce), .irq_o(irq)
  );

  // fabric model and beat capture
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!cfg_ncfg) begin
      fab_nst <= 1'b0; fab_cd <= 1'b0; rel_cnt <= 0;
    end else if (fab_kill) begin
      fab_nst <= 1'b0;
    end else if (!fab_nst) begin
      if (rel_cnt == 3) fab_nst <= 1'b1;
      else rel_cnt <= rel_cnt + 1;
    end
    if (cfg_dclk) begin
      cap[n & 255]   <= cfg_data;
      stamp[n & 255] <= cyc;
      n <= n + 1;
      if (fab_nst && !fab_cd && expect_beats != 0 && (n + 1 - beat_base) >= expect_beats)
        fab_cd <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 3'(a); wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    addr = 3'(a);
    #1 d = rdata;
  endtask

  task automatic idle(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic wait_phase(input string tag, input logic [2:0] exp);
    logic [31:0] d;
    for (int i = 0; i < 200; i++) begin
      rd(1, d);
      if (d[2:0] == exp) break;
    end
    chk(tag, {29'd0, d[2:0]}, {29'd0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(0, d); chk("R1 ctrl reset", d, 32'h10);
    rd(1, d); chk("R1 phase reset", {29'd0, d[2:0]}, 32'd0);
    rd(5, d); chk("R1 done reset", d, 32'd0);
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    chk("R1 nce reset", {31'd0, cfg_nce}, 32'd1);
  endtask

  task automatic t_takeover;
    ext_data = 32'h5A5A1234; ext_dclk = 1'b1; ext_ncfg = 1'b0;
    #1;
    chk("R2 ext data", cfg_data, 32'h5A5A1234);
    chk("R2 ext dclk", {31'd0, cfg_dclk}, 32'd1);
    chk("R2 ext ncfg low", {31'd0, cfg_ncfg}, 32'd0);
    ext_dclk = 1'b0; ext_ncfg = 1'b1;
    #1 chk("R2 ext ncfg high", {31'd0, cfg_ncfg}, 32'd1);
    wr(0, 32'h60); // own, pull, ce_n=0
    #1;
    chk("R2 own ncfg pulled", {31'd0, cfg_ncfg}, 32'd0);
    chk("R2 own data", cfg_data, 32'd0);
    chk("R1 nce follows bit", {31'd0, cfg_nce}, 32'd0);
  endtask

  task automatic t_phase_reset;
    idle(10);
    wait_phase("R3 reset phase", 3'd0);
    wr(0, 32'h20);
    wait_phase("R3 config phase", 3'd1);
  endtask

  task automatic t_drop;
    int base;
    base = n;
    wr(6, 32'hDEADBEEF);
    idle(20);
    chk("R4 dropped write", 32'(n - base), 32'd0);
  endtask

  task automatic t_w8;
    int base;
    logic [31:0] exp [4] = '{32'hD4, 32'hC3, 32'hB2, 32'hA1};
    wr(0, 32'hA0);
    base = n;
    wr(6, 32'hA1B2C3D4);
    idle(20);
    chk("R5 w8 beat count", 32'(n - base), 32'd4);
    for (int i = 0; i < 4; i++) chk("R5 w8 beat", cap[(base + i) & 255], exp[i]);
    for (int i = 1; i < 4; i++)
      chk("R6 w8 spacing", 32'(stamp[(base + i) & 255] - stamp[(base + i - 1) & 255]), 32'd2);
  endtask

  task automatic t_w16;
    int base;
    wr(0, 32'hA5);
    base = n;
    wr(6, 32'h11223344);
    idle(20);
    chk("R5 w16 beat count", 32'(n - base), 32'd2);
    chk("R5 w16 beat0", cap[base & 255], 32'h3344);
    chk("R5 w16 beat1", cap[(base + 1) & 255], 32'h1122);
    chk("R6 ratio1 spacing", 32'(stamp[(base + 1) & 255] - stamp[base & 255]), 32'd4);
  endtask

  task automatic t_w32;
    int base;
    logic [31:0] d;
    wr(0, 32'hA8);
    base = n; beat_base = n; expect_beats = 1;
    wr(6, 32'hCAFEF00D);
    idle(20);
    chk("R5 w32 beat count", 32'(n - base), 32'd1);
    chk("R5 w32 beat", cap[base & 255], 32'hCAFEF00D);
    wait_phase("R7 init phase", 3'd2);
    rd(2, d); chk("R7 pins ok", {30'd0, d[1:0]}, 32'd3);
    expect_beats = 0;
  endtask

  task automatic t_burst;
    int base;
    logic [31:0] d;
    wr(0, 32'h20);
    wr(5, 32'd1);
    base = n;
    wr(4, 32'd4);
    idle(20);
    chk("R8 burst count 4", 32'(n - base), 32'd4);
    for (int i = 1; i < 4; i++)
      chk("R8 burst spacing", 32'(stamp[(base + i) & 255] - stamp[(base + i - 1) & 255]), 32'd2);
    rd(5, d); chk("R9 done set", d, 32'd1);
    wait_phase("R9 user phase", 3'd3);
    idle(10);
    rd(5, d); chk("R9 done sticky", d, 32'd1);
    wr(5, 32'd1);
    rd(5, d); chk("R9 done cleared", d, 32'd0);
    base = n;
    wr(4, 32'd20);
    wr(4, 32'd3);
    idle(60);
    chk("R8 reload ignored", 32'(n - base), 32'd20);
  endtask

  task automatic t_error;
    logic [31:0] d;
    wr(0, 32'h60);
    wait_phase("R3 reset again", 3'd0);
    wr(0, 32'h20);
    wait_phase("R3 config again", 3'd1);
    wr(3, 32'd1);
    rd(2, d); chk("R11 irq cleared", {31'd0, d[2]}, 32'd0);
    chk("R11 irq pin cleared", {31'd0, irq}, 32'd0);
    fab_kill = 1'b1;
    wait_phase("R10 error phase", 3'd4);
    rd(2, d); chk("R11 irq flag set", {31'd0, d[2]}, 32'd1);
    chk("R11 irq pin set", {31'd0, irq}, 32'd1);
    idle(10);
    rd(1, d); chk("R10 error holds", {29'd0, d[2:0]}, 32'd4);
    wr(3, 32'd1);
    rd(2, d); chk("R11 irq ack", {31'd0, d[2]}, 32'd0);
    fab_kill = 1'b0;
    wr(0, 32'h60);
    wait_phase("R10 leave error", 3'd0);
  endtask

  always @(posedge clk) begin
    if (cyc == 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    t_reset();
    t_takeover();
    t_phase_reset();
    t_drop();
    t_w8();
    t_w16();
    t_w32();
    t_burst();
    t_error();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule